// File: doc/BRIEF.md
# Iterative Per-Router Voltage/Frequency Step Controller

This block is the central decision engine for run-time power reduction in a small mesh of routers. After a restart it puts every router at the fastest operating point and stores a latency target. It then waits for one report per application frame: the measured execution time of that frame and the peak load each router saw in its window. For each report it decides whether to slow down one more router, to probe a further slowdown, or to undo the last change and stop. The operating points form an ordered ladder. Index 0 is 300 MHz at 1.32 V. Index 1 is the first point on the low supply rail (200 MHz at 1.1 V). Higher indices are slower frequencies on that same rail. Only index 0 to index 1 changes the supply voltage.

The search is greedy. If a frame meets the deadline, the least-loaded router that is not yet at the slowest point moves down one rung. If the execution time jumps sharply while still inside the deadline, the same router is pushed down one more rung as a probe. The next frame then decides whether to keep going or to revert and freeze. A missed deadline undoes the most recent change and ends the search. The frame times and loads are supplied on ports. Collecting them is outside this block.

Top module: `dvfs_greedy_mgr`

## Requirements
- R1: A cycle with `start_i` high clears every router index to 0, stores `deadline_i`, clears any pending probe and the frame history, and drops `done_o`. These effects are visible from the following cycle.
- R2: In the running state, a frame report whose time is at or below the deadline lowers the chosen router by exactly one index. In the next cycle `step_valid_o` is 1, `step_up_o` is 0 and `step_router_o` holds that router.
- R3: Routers already at the slowest index (NUM_LEVELS-1) are never chosen. Among the remaining routers the lowest peak load wins, and a tie goes to the lower router number (router n occupies bits n*LW and up of `peak_load_i`, and index bits n*LVW and up of `op_level_o`).
- R4: `step_vf_o` is 1 exactly when the reported step crosses the boundary between index 0 and index 1, in either direction. Every other step reports 0 (frequency only).
- R5: If the deadline is missed while no probe is pending, the last lowered router moves up one index and `done_o` rises. If no router has been lowered since the start, `done_o` rises with no index change.
- R6: A frame within the deadline whose time exceeds the previous frame's time by more than RISE_MARGIN is a sudden rise. It lowers the last lowered router once more as a probe, instead of running the lowest-load pick. This applies only when that router is not at the slowest index.
- R7: The frame after a probe resumes the normal greedy step if its time is within the deadline and strictly below the rise frame's time. Otherwise the probed router moves up one index and `done_o` rises.
- R8: When a frame meets the deadline and every router is at the slowest index, `done_o` rises and no step is issued.
- R9: While `done_o` is high, frame reports change no router index and produce no step until the next start.
- R10: A deadline miss has priority over a sudden rise in the same frame. A start has priority over a frame report in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart search, load deadline |
| deadline_i | input | TW | Frame latency target |
| frame_valid_i | input | 1 | One-cycle pulse: a frame report is present |
| frame_time_i | input | TW | Measured execution time of the frame |
| peak_load_i | input | N*LW | Peak load per router, router n at bits n*LW |
| op_level_o | output | N*LVW | Operating-point index per router, 0 is fastest |
| step_valid_o | output | 1 | An index changed in the previous cycle |
| step_router_o | output | IW | Router that changed |
| step_up_o | output | 1 | 1 when the change moved back to a faster point |
| step_vf_o | output | 1 | 1 when the change also switched the voltage |
| done_o | output | 1 | Search finished, outputs frozen |

## Verification
Two functions can be triggered by the same frame report: sudden-rise detection and deadline-miss handling. The bench provokes this with a frame whose time is both far above the previous one and above the deadline. It then expects a one-index revert of the last router and a finished search, not a probe. The same kind of collision happens when a start and a frame report arrive in one cycle, and the bench expects a clean restart. A reference model written from the requirements predicts the index vector, the step report and the done flag for every report. A scoreboard compares that prediction one cycle after each input event.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
   typedef enum logic [1:0] {
      MGR_IDLE = 2'd0,
      MGR_RUN  = 2'd1,
      MGR_DONE = 2'd2
   } mgr_state_e;
endpackage

// File: rtl/dvfs_lowload_pick.sv
module dvfs_lowload_pick #(
   parameter int N          = 9,
   parameter int LW         = 8,
   parameter int NUM_LEVELS = 6,
   localparam int LVW       = $clog2(NUM_LEVELS),
   localparam int IW        = $clog2(N)
) (
   input  logic [N*LW-1:0]  loads_i,
   input  logic [N*LVW-1:0] levels_i,
   output logic             found_o,
   output logic [IW-1:0]    idx_o
);
   localparam logic [LVW-1:0] MAXL = LVW'(NUM_LEVELS - 1);

   logic [LW-1:0] best;

   // strict less-than keeps the lower router number on a tie
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      best    = '1;
      for (int i = 0; i < N; i++) begin
         if (levels_i[i*LVW +: LVW] != MAXL &&
             (!found_o || loads_i[i*LW +: LW] < best)) begin
            found_o = 1'b1;
            best    = loads_i[i*LW +: LW];
            idx_o   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/dvfs_level_bank.sv
module dvfs_level_bank #(
   parameter int N          = 9,
   parameter int NUM_LEVELS = 6,
   localparam int LVW       = $clog2(NUM_LEVELS),
   localparam int IW        = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             upd_en_i,
   input  logic [IW-1:0]    upd_idx_i,
   input  logic             upd_up_i,
   output logic [N*LVW-1:0] levels_o
);
   localparam logic [LVW-1:0] MAXL = LVW'(NUM_LEVELS - 1);

   for (genvar g = 0; g < N; g++) begin : g_rtr
      logic [LVW-1:0] lvl_q;
      logic           hit;
      assign hit = upd_en_i && (upd_idx_i == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          lvl_q <= '0;
         else if (clear_i)    lvl_q <= '0;
         else if (hit)        lvl_q <= upd_up_i ? lvl_q - 1'b1 : lvl_q + 1'b1;
      end
      assign levels_o[g*LVW +: LVW] = lvl_q;

      AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_q <= MAXL);                                          // R3
      AST_NO_STEP_BELOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !clear_i && !upd_up_i) |-> lvl_q != MAXL);        // R8
      AST_NO_STEP_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !clear_i && upd_up_i) |-> lvl_q != '0);           // R5
   end
endmodule

// File: rtl/dvfs_greedy_mgr.sv
module dvfs_greedy_mgr
   import dvfs_pkg::*;
#(
   parameter int N             = 9,
   parameter int LW            = 8,
   parameter int TW            = 16,
   parameter int NUM_LEVELS    = 6,
   parameter int VCHANGE_LEVEL = 1,
   parameter int RISE_MARGIN   = 16,
   localparam int LVW          = $clog2(NUM_LEVELS),
   localparam int IW           = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [TW-1:0]    deadline_i,
   input  logic             frame_valid_i,
   input  logic [TW-1:0]    frame_time_i,
   input  logic [N*LW-1:0]  peak_load_i,
   output logic [N*LVW-1:0] op_level_o,
   output logic             step_valid_o,
   output logic [IW-1:0]    step_router_o,
   output logic             step_up_o,
   output logic             step_vf_o,
   output logic             done_o
);
   localparam logic [LVW-1:0] MAXL = LVW'(NUM_LEVELS - 1);
   localparam logic [LVW-1:0] VCHL = LVW'(VCHANGE_LEVEL);

   initial begin
      assert (N >= 2) else $error("N must be at least 2");
      assert (NUM_LEVELS >= 2) else $error("NUM_LEVELS must be at least 2");
      assert (VCHANGE_LEVEL >= 1 && VCHANGE_LEVEL < NUM_LEVELS)
         else $error("VCHANGE_LEVEL out of range");
      assert (RISE_MARGIN >= 0 && RISE_MARGIN < (1 << TW))
         else $error("RISE_MARGIN out of range");
   end

   mgr_state_e     state_q, state_d;
   logic [TW-1:0]  deadline_q, prev_time_q, rise_time_q, rise_time_d;
   logic           have_prev_q, probe_q, probe_d, last_v_q, last_v_d;
   logic [IW-1:0]  last_idx_q, last_idx_d;
   logic           upd_en, upd_up, do_greedy, met, rise, vf_d, accept;
   logic [IW-1:0]  upd_idx;
   logic           pick_found;
   logic [IW-1:0]  pick_idx;
   logic [LVW-1:0] lvl_arr [N];

   for (genvar g = 0; g < N; g++) begin : g_unpack
      assign lvl_arr[g] = op_level_o[g*LVW +: LVW];
   end

   dvfs_lowload_pick #(.N(N), .LW(LW), .NUM_LEVELS(NUM_LEVELS)) i_pick (
      .loads_i  (peak_load_i),
      .levels_i (op_level_o),
      .found_o  (pick_found),
      .idx_o    (pick_idx)
   );

   dvfs_level_bank #(.N(N), .NUM_LEVELS(NUM_LEVELS)) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_i),
      .upd_en_i  (upd_en),
      .upd_idx_i (upd_idx),
      .upd_up_i  (upd_up),
      .levels_o  (op_level_o)
   );

   assign accept = !start_i && frame_valid_i && (state_q == MGR_RUN);
   assign met    = frame_time_i <= deadline_q;
   assign rise   = have_prev_q &&
                   ({1'b0, frame_time_i} > ({1'b0, prev_time_q} + (TW+1)'(RISE_MARGIN)));

   always_comb begin
      state_d     = state_q;
      probe_d     = probe_q;
      last_v_d    = last_v_q;
      last_idx_d  = last_idx_q;
      rise_time_d = rise_time_q;
      upd_en      = 1'b0;
      upd_up      = 1'b0;
      upd_idx     = last_idx_q;
      do_greedy   = 1'b0;
      if (accept) begin
         if (probe_q) begin
            probe_d = 1'b0;
            if (met && frame_time_i < rise_time_q) begin
               do_greedy = 1'b1;
            end else begin
               upd_en  = 1'b1;
               upd_up  = 1'b1;
               state_d = MGR_DONE;
            end
         end else if (!met) begin
            upd_en  = last_v_q;
            upd_up  = 1'b1;
            state_d = MGR_DONE;
         end else if (rise && last_v_q && lvl_arr[last_idx_q] != MAXL) begin
            upd_en      = 1'b1;
            probe_d     = 1'b1;
            rise_time_d = frame_time_i;
         end else begin
            do_greedy = 1'b1;
         end
         if (do_greedy) begin
            if (pick_found) begin
               upd_en     = 1'b1;
               upd_idx    = pick_idx;
               last_idx_d = pick_idx;
               last_v_d   = 1'b1;
            end else begin
               state_d = MGR_DONE;
            end
         end
      end
      vf_d = upd_up ? (lvl_arr[upd_idx] == VCHL)
                    : (lvl_arr[upd_idx] + 1'b1 == VCHL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= MGR_IDLE;
         deadline_q    <= '0;
         prev_time_q   <= '0;
         rise_time_q   <= '0;
         have_prev_q   <= 1'b0;
         probe_q       <= 1'b0;
         last_v_q      <= 1'b0;
         last_idx_q    <= '0;
         step_valid_o  <= 1'b0;
         step_router_o <= '0;
         step_up_o     <= 1'b0;
         step_vf_o     <= 1'b0;
      end else if (start_i) begin
         state_q       <= MGR_RUN;
         deadline_q    <= deadline_i;
         have_prev_q   <= 1'b0;
         probe_q       <= 1'b0;
         last_v_q      <= 1'b0;
         last_idx_q    <= '0;
         step_valid_o  <= 1'b0;
      end else begin
         state_q       <= state_d;
         probe_q       <= probe_d;
         last_v_q      <= last_v_d;
         last_idx_q    <= last_idx_d;
         rise_time_q   <= rise_time_d;
         step_valid_o  <= upd_en;
         if (upd_en) begin
            step_router_o <= upd_idx;
            step_up_o     <= upd_up;
            step_vf_o     <= vf_d;
         end
         if (accept) begin
            prev_time_q <= frame_time_i;
            have_prev_q <= 1'b1;
         end
      end
   end

   assign done_o = (state_q == MGR_DONE);

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (op_level_o == '0 && !done_o));                  // R1
   AST_STEP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid_o |-> $past(frame_valid_i));                      // R2
   AST_PICK_NOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found |-> lvl_arr[pick_idx] != MAXL);                   // R3
   AST_REVERT_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid_o && step_up_o) |-> done_o);                     // R5
   AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> ($stable(op_level_o) && !step_valid_o)); // R9
endmodule

// File: tb/test_dvfs_greedy_mgr.sv
module test_dvfs_greedy_mgr;
   localparam int N = 9, LW = 8, TW = 16, NL = 6, LVW = 3, IW = 4, MARGIN = 16;
   localparam int MAXL = NL - 1;

   typedef struct {
      logic [N*LVW-1:0] lv;
      logic             dn;
      logic             sv;
      logic [IW-1:0]    sr;
      logic             su;
      logic             sf;
      string            req;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, frame_valid_i = 1'b0;
   logic [TW-1:0] deadline_i = '0, frame_time_i = '0;
   logic [N*LW-1:0] peak_load_i;
   logic [N*LVW-1:0] op_level_o;
   logic step_valid_o, step_up_o, step_vf_o, done_o;
   logic [IW-1:0] step_router_o;

   int ld [N];
   int vectors = 0, errors = 0;
   exp_t q [$];

   // reference model state
   int mlvl [N];
   int mrun, mprobe, mlastv, mlast, mhp, mprev, mrise, mdl;
   exp_t cur;

   always #4 clk = ~clk;

   always_comb
      for (int i = 0; i < N; i++) peak_load_i[i*LW +: LW] = LW'(ld[i]);

   dvfs_greedy_mgr i_dvfs_greedy_mgr (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .deadline_i(deadline_i),
      .frame_valid_i(frame_valid_i), .frame_time_i(frame_time_i),
      .peak_load_i(peak_load_i), .op_level_o(op_level_o),
      .step_valid_o(step_valid_o), .step_router_o(step_router_o),
      .step_up_o(step_up_o), .step_vf_o(step_vf_o), .done_o(done_o));

   function automatic logic [N*LVW-1:0] pack_lv();
      logic [N*LVW-1:0] r;
      for (int i = 0; i < N; i++) r[i*LVW +: LVW] = LVW'(mlvl[i]);
      return r;
   endfunction

   task automatic m_move(input int r, input bit up);
      cur.sv = 1'b1; cur.sr = IW'(r); cur.su = up;
      cur.sf = up ? (mlvl[r] == 1) : (mlvl[r] + 1 == 1);
      mlvl[r] = up ? mlvl[r] - 1 : mlvl[r] + 1;
   endtask

   task automatic m_start(input int dl);
      for (int i = 0; i < N; i++) mlvl[i] = 0;
      mrun = 1; mprobe = 0; mlastv = 0; mhp = 0; mdl = dl;
   endtask

   task automatic m_frame(input int t);
      bit greedy = 0;
      if (mrun != 1) return;
      if (mprobe != 0) begin
         mprobe = 0;
         if (t <= mdl && t < mrise) greedy = 1;
         else begin m_move(mlast, 1); mrun = 2; end
      end else if (t > mdl) begin
         if (mlastv != 0) m_move(mlast, 1);
         mrun = 2;
      end else if (mhp != 0 && t > mprev + MARGIN && mlastv != 0 && mlvl[mlast] < MAXL) begin
         m_move(mlast, 0); mprobe = 1; mrise = t;
      end else greedy = 1;
      if (greedy) begin
         int sel = -1;
         for (int i = 0; i < N; i++)
            if (mlvl[i] < MAXL && (sel < 0 || ld[i] < ld[sel])) sel = i;
         if (sel < 0) mrun = 2;
         else begin m_move(sel, 0); mlast = sel; mlastv = 1; end
      end
      mprev = t; mhp = 1;
   endtask

   task automatic push_exp(input string req);
      cur.lv = pack_lv(); cur.dn = (mrun == 2); cur.req = req;
      q.push_back(cur);
   endtask

   task automatic do_start(input int dl, input string req);
      @(negedge clk);
      start_i = 1'b1; deadline_i = TW'(dl);
      cur.sv = 0; cur.sr = 0; cur.su = 0; cur.sf = 0;
      m_start(dl); push_exp(req);
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic do_frame(input int t, input string req);
      @(negedge clk);
      frame_valid_i = 1'b1; frame_time_i = TW'(t);
      cur.sv = 0; cur.sr = 0; cur.su = 0; cur.sf = 0;
      m_frame(t); push_exp(req);
      @(negedge clk); frame_valid_i = 1'b0;
   endtask

   task automatic do_start_and_frame(input int dl, input int t, input string req);
      @(negedge clk);
      start_i = 1'b1; frame_valid_i = 1'b1; deadline_i = TW'(dl); frame_time_i = TW'(t);
      cur.sv = 0; cur.sr = 0; cur.su = 0; cur.sf = 0;
      m_start(dl); push_exp(req);
      @(negedge clk); start_i = 1'b0; frame_valid_i = 1'b0;
   endtask

   // monitor: compare one cycle after each start or frame report
   initial forever begin
      @(posedge clk);
      if (start_i || frame_valid_i) begin
         exp_t e;
         @(negedge clk);
         e = q.pop_front();
         vectors++;
         if (op_level_o !== e.lv || done_o !== e.dn || step_valid_o !== e.sv ||
             (e.sv && (step_router_o !== e.sr || step_up_o !== e.su || step_vf_o !== e.sf))) begin
            errors++;
            $display("FAIL %s: lv=%h dn=%b sv=%b sr=%0d su=%b sf=%b expected lv=%h dn=%b sv=%b sr=%0d su=%b sf=%b",
                     e.req, op_level_o, done_o, step_valid_o, step_router_o, step_up_o, step_vf_o,
                     e.lv, e.dn, e.sv, e.sr, e.su, e.sf);
         end
      end
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      ld = '{60, 20, 20, 90, 70, 80, 75, 85, 95};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      vectors++;
      if (op_level_o !== '0 || done_o !== 1'b0 || step_valid_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: lv=%h dn=%b sv=%b expected lv=0 dn=0 sv=0",
                  op_level_o, done_o, step_valid_o);
      end
      do_start(1000, "R1");
      // R2 R3 R4: router 1 wins the tie, first step switches voltage
      for (int k = 0; k < 6; k++) do_frame(500, "R2_R3_R4");
      do_frame(600, "R6");          // sudden rise: probe router 2
      do_frame(550, "R7");          // improved: greedy resumes
      do_frame(1200, "R5");         // miss: revert, finish
      do_frame(500, "R9");          // ignored while finished
      do_start(1000, "R1");
      do_frame(500, "R2");
      do_frame(600, "R6");
      do_frame(650, "R7");          // not improved: revert probe, finish
      do_frame(400, "R9");
      do_start(1000, "R1");
      do_frame(1200, "R5");         // miss before any step
      do_start(800, "R1");
      do_frame(500, "R2");
      do_frame(900, "R10");         // rise and miss together: miss wins
      do_start_and_frame(1000, 500, "R10");
      ld = '{10, 10, 10, 10, 10, 10, 10, 10, 10};
      for (int k = 0; k < 46; k++) do_frame(500, "R8_R3");
      do_frame(500, "R9");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule